// File: doc/BRIEF.md
# General-Purpose I/O Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port. Software reaches it through a small memory-mapped register set. One register holds the output data and another sets, pin by pin, which pins drive their data bit. A read-only view shows the synchronized level on every pin, whatever the direction of that pin.

Each pin has its own 2-bit trigger condition: low level, high level, rising edge or falling edge. A condition that is detected sets a sticky status bit. Software clears that bit by writing a one to it. An enable register gates the status onto three interrupt lines. One line serves pins 0 to 15, one serves pins 16 to 31, and a third is the OR of both.

Each pin passes through a two-flop synchronizer before detection. Edges are found by comparing two consecutive synchronized samples. A level condition sets its status bit again on every cycle that it holds. If a new detection and a clear by software hit the same bit in the same cycle, the detection wins.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, every register reads 0 and `pin_out`, `pin_oe`, `irq_lo`, `irq_hi` and `irq_any` are all 0.
- R2: `pin_out` equals the data register. `pin_oe` equals the direction register, where 1 means the pin drives.
- R3: The pad register returns `pin_in` two clock edges after it is applied, and returns it for input and output pins alike. One edge after the change it still shows the old value.
- R4: The trigger code of pin n sits in bits [2*(n mod 16)+1 : 2*(n mod 16)]. Pins 0 to 15 use the lower config register and pins 16 to 31 use the upper one. Both config registers read back what was written.
- R5: The trigger codes are 0 for low level, 1 for high level, 2 for a rising edge and 3 for a falling edge. An edge is a change between two consecutive synchronized samples.
- R6: A level condition sets its status bit on every cycle that it holds. A clear therefore does not stay while the level persists.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Status bits never fall without such a write.
- R8: A detection that lands on a status bit in the same cycle as a write-one-to-clear of that bit leaves the bit set.
- R9: `irq_lo` is the OR of status AND enable over pins 0 to 15, and `irq_hi` is the same over pins 16 to 31. `irq_any` is their OR. Status bits latch even while their enable bit is 0.
- R10: The byte offsets are: data 0x00, direction 0x04, pad 0x08, lower config 0x0C, upper config 0x10, enable 0x14, status 0x18. Other offsets read 0. Writes to the pad register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |
| irq_any | output | 1 | OR of both interrupt lines |

## Verification
The hardest case to reach is a detection and a clear that land on the same status bit in the same cycle. That case needs the write strobe to be placed exactly at the edge where a pin change leaves the synchronizer. The bench changes a pin in edge mode, counts two falling clock edges, and then issues the clear so that it lands at that edge. A second clear one cycle later shows that the bit can be cleared once the edge has passed. The field layout is swept with four rotations of the trigger codes across all 32 pins under several pin-change patterns, so every pin is tested in every mode.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS  = 32;
    localparam int HALF   = NPINS / 2;
    localparam int ADDR_W = 5;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PAD    = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CFG_LO = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG_HI = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h18;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NPINS-1:0]  wdata;
    } bus_req_t;

    typedef struct packed {
        logic [NPINS-1:0] data;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] cfg_lo;
        logic [NPINS-1:0] cfg_hi;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] status;
    } port_regs_t;

    // Trigger code of pin n taken from the two packed config words.
    function automatic trig_e pin_trig(input logic [NPINS-1:0] lo,
                                       input logic [NPINS-1:0] hi,
                                       input int n);
        int base;
        base = CODE_W * (n % HALF);
        if (n < HALF) return trig_e'(lo[base +: CODE_W]);
        else          return trig_e'(hi[base +: CODE_W]);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int W = NPINS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] cfg_lo,
    input  logic [W-1:0] cfg_hi,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        trig_e code;
        assign code = pin_trig(cfg_lo, cfg_hi, i);
        always_comb begin
            unique case (code)
                TRIG_LOW:  set_vec[i] = ~cur[i];
                TRIG_HIGH: set_vec[i] =  cur[i];
                TRIG_RISE: set_vec[i] =  cur[i] & ~prev[i];
                TRIG_FALL: set_vec[i] = ~cur[i] &  prev[i];
                default:   set_vec[i] = 1'b0;
            endcase
        end
    end

    // R5: an edge-mode detection only occurs when the sample changed
    a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
        (set_vec & ~(cur ^ prev) & ~(cfg_level_mask(cfg_lo, cfg_hi))) == '0);

    function automatic logic [W-1:0] cfg_level_mask(input logic [W-1:0] lo,
                                                    input logic [W-1:0] hi);
        logic [W-1:0] m;
        for (int n = 0; n < W; n++)
            m[n] = (pin_trig(lo, hi, n) == TRIG_LOW) ||
                   (pin_trig(lo, hi, n) == TRIG_HIGH);
        return m;
    endfunction
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [NPINS-1:0] pad,
    input  logic [NPINS-1:0] set_vec,
    output logic [NPINS-1:0] rdata,
    output port_regs_t       regs
);
    port_regs_t       q;
    logic [NPINS-1:0] clr;

    assign clr = (req.wr && req.addr == OFS_STAT) ? req.wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (req.wr) begin
                case (req.addr)
                    OFS_DATA:   q.data   <= req.wdata;
                    OFS_DIR:    q.dir    <= req.wdata;
                    OFS_CFG_LO: q.cfg_lo <= req.wdata;
                    OFS_CFG_HI: q.cfg_hi <= req.wdata;
                    OFS_MASK:   q.mask   <= req.wdata;
                    default:    ;
                endcase
            end
            // detection has priority over the clear
            q.status <= (q.status & ~clr) | set_vec;
        end
    end

    always_comb begin
        case (req.addr)
            OFS_DATA:   rdata = q.data;
            OFS_DIR:    rdata = q.dir;
            OFS_PAD:    rdata = pad;
            OFS_CFG_LO: rdata = q.cfg_lo;
            OFS_CFG_HI: rdata = q.cfg_hi;
            OFS_MASK:   rdata = q.mask;
            OFS_STAT:   rdata = q.status;
            default:    rdata = '0;
        endcase
    end

    assign regs = q;

    // R7: cleared bits without a concurrent detection are zero afterwards
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == OFS_STAT) |=>
        ((q.status & $past(req.wdata & ~set_vec)) == '0));

    // R7: without a status write no bit ever falls
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_STAT) |=>
        (($past(q.status) & ~q.status) == '0));

    // R8: a detection always lands, whatever the bus does
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((q.status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_any
);
    bus_req_t         req;
    port_regs_t       regs;
    logic [NPINS-1:0] pad;
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] pending;

    assign req = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .dout(pad)
    );

    gpio_detect #(.W(NPINS)) u_detect (
        .clk(clk), .rst(rst), .cur(pad),
        .cfg_lo(regs.cfg_lo), .cfg_hi(regs.cfg_hi), .set_vec(set_vec)
    );

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .pad(pad), .set_vec(set_vec),
        .rdata(bus_rdata), .regs(regs)
    );

    assign pending = regs.status & regs.mask;
    assign irq_lo  = |pending[HALF-1:0];
    assign irq_hi  = |pending[NPINS-1:HALF];
    assign irq_any = irq_lo | irq_hi;
    assign pin_out = regs.data;
    assign pin_oe  = regs.dir;

    // R9: with every enable off no interrupt line rises
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (regs.mask == '0) |-> !irq_any);

    // R9: an interrupt line implies some enabled status bit in its half
    a_r9_hi_source: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> ((regs.status[NPINS-1:HALF] & regs.mask[NPINS-1:HALF]) != '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    import gpio_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [31:0]       pin_in = '0;
    logic [31:0]       pin_out, pin_oe;
    logic              irq_lo, irq_hi, irq_any;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo),
        .irq_hi(irq_hi), .irq_any(irq_any)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int mode_of(input int k, input int n);
        return (n + k) % 4;
    endfunction

    function automatic logic [31:0] cfg_word(input int k, input int h);
        logic [31:0] w;
        for (int j = 0; j < 16; j++) w[2*j +: 2] = 2'(mode_of(k, h*16 + j));
        return w;
    endfunction

    function automatic logic [31:0] lvl(input int k, input logic [31:0] p);
        logic [31:0] r;
        for (int n = 0; n < 32; n++)
            r[n] = (mode_of(k, n) == 0) ? !p[n] : (mode_of(k, n) == 1) ? p[n] : 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] edg(input int k, input logic [31:0] a,
                                        input logic [31:0] b);
        logic [31:0] r;
        for (int n = 0; n < 32; n++)
            r[n] = (mode_of(k, n) == 2) ? (!a[n] && b[n]) :
                   (mode_of(k, n) == 3) ? (a[n] && !b[n]) : 1'b0;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pa [4];
        logic [31:0] pb [4];
        pa[0] = 32'h0000_0000; pb[0] = 32'hFFFF_FFFF;
        pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0000;
        pa[2] = 32'h0F0F_A5C3; pb[2] = 32'hF0F0_5A3C;
        pa[3] = 32'h1234_8001; pb[3] = 32'h1335_7F03;

        // R1: reset state
        pin_in = 32'hDEAD_BEEF;
        step(3);
        for (int a = 0; a < 8; a++) begin
            rd(5'(a*4), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset outputs", {pin_out ^ pin_oe, 29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
        check("R1 reset pin_out", pin_out, 32'h0);
        rst = 1'b0;
        pin_in = 32'h0;
        step(4);

        // R10 R4: readback of the writable registers
        wr(OFS_DATA,   32'hA5A5_0F0F);
        wr(OFS_DIR,    32'h00FF_F00F);
        wr(OFS_CFG_LO, 32'h1B1B_E4E4);
        wr(OFS_CFG_HI, 32'h8765_4321);
        rd(OFS_DATA, v);   check("R10 data readback", v, 32'hA5A5_0F0F);
        rd(OFS_DIR, v);    check("R10 dir readback", v, 32'h00FF_F00F);
        rd(OFS_CFG_LO, v); check("R4 cfg lo readback", v, 32'h1B1B_E4E4);
        rd(OFS_CFG_HI, v); check("R4 cfg hi readback", v, 32'h8765_4321);
        rd(OFS_MASK, v);   check("R10 mask still zero", v, 32'h0);
        wr(OFS_MASK, 32'h0000_0000);
        rd(5'h1C, v);      check("R10 unmapped offset", v, 32'h0);

        // R2: outputs follow data and direction
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'h00FF_F00F);

        // R3 R10: pad sampling latency, write to pad ignored
        for (int t = 0; t < 4; t++) begin
            logic [31:0] old;
            old = pin_in;
            pin_in = pb[t];
            step(1);
            rd(OFS_PAD, v); check("R3 pad one edge later", v, old);
            step(1);
            rd(OFS_PAD, v); check("R3 pad two edges later", v, pb[t]);
        end
        wr(OFS_PAD, 32'h5555_AAAA);
        rd(OFS_PAD, v); check("R10 pad write ignored", v, pb[3]);

        // R4 R5 R6: sweep of trigger codes over every pin
        for (int k = 0; k < 4; k++) begin
            wr(OFS_CFG_LO, cfg_word(k, 0));
            wr(OFS_CFG_HI, cfg_word(k, 1));
            for (int t = 0; t < 4; t++) begin
                pin_in = pa[t];
                step(4);
                wr(OFS_STAT, 32'hFFFF_FFFF);
                step(2);
                rd(OFS_STAT, v);
                check("R6 level survives clear", v, lvl(k, pa[t]));
                pin_in = pb[t];
                step(4);
                rd(OFS_STAT, v);
                check("R5 R4 detection sweep", v,
                      lvl(k, pa[t]) | lvl(k, pb[t]) | edg(k, pa[t], pb[t]));
                check("R9 no irq while masked", {31'h0, irq_any}, 32'h0);
            end
        end

        // R9 R7: all rising edge mode, controlled status
        wr(OFS_CFG_LO, 32'hAAAA_AAAA);
        wr(OFS_CFG_HI, 32'hAAAA_AAAA);
        pin_in = 32'h0;
        step(4);
        wr(OFS_STAT, 32'hFFFF_FFFF);
        pin_in = 32'h0010_0008;
        step(4);
        rd(OFS_STAT, v); check("R9 status latched unmasked", v, 32'h0010_0008);
        wr(OFS_MASK, 32'h0000_FFFF);
        check("R9 lower half only", {29'h0, irq_lo, irq_hi, irq_any}, 32'h5);
        wr(OFS_MASK, 32'h0010_0000);
        check("R9 upper half only", {29'h0, irq_lo, irq_hi, irq_any}, 32'h3);
        wr(OFS_MASK, 32'hFFEF_FFF7);
        check("R9 enables miss pending", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);
        wr(OFS_MASK, 32'hFFFF_FFFF);
        wr(OFS_STAT, 32'h0000_0000);
        rd(OFS_STAT, v); check("R7 zero write keeps bits", v, 32'h0010_0008);
        wr(OFS_STAT, 32'h0000_0008);
        rd(OFS_STAT, v); check("R7 one write clears bit", v, 32'h0010_0000);
        check("R9 lines after clear", {29'h0, irq_lo, irq_hi, irq_any}, 32'h3);
        wr(OFS_STAT, 32'h0010_0000);
        check("R9 lines idle", {29'h0, irq_lo, irq_hi, irq_any}, 32'h0);

        // R8: detection and clear in the same cycle
        pin_in = 32'h0010_0088;
        step(2);
        wr(OFS_STAT, 32'h0000_0080);
        rd(OFS_STAT, v); check("R8 set beats clear", v & 32'h80, 32'h80);
        wr(OFS_STAT, 32'h0000_0080);
        rd(OFS_STAT, v); check("R8 later clear works", v, 32'h0);

        // R6: high level held on pin 5
        wr(OFS_CFG_LO, 32'hAAAA_A6AA);
        pin_in = 32'h0010_00A8;
        step(4);
        wr(OFS_STAT, 32'hFFFF_FFFF);
        rd(OFS_STAT, v); check("R6 level re-sets after clear", v, 32'h0000_0020);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule